// File: doc/BRIEF.md
# Two-Read One-Write Register File with Constant-Zero Entry

This block is a small multi-ported storage array meant to sit beside an integer datapath. It holds a set of data words selected by a binary index. Two independent read ports return the word at their index with no clock involved. One write port stores a word on the rising clock edge when its enable is high. Index 0 is not a storage cell. It is a constant that always reads back as all zeros, and any write aimed at it is dropped without effect.

Reads see the contents as they stand before the next clock edge. A read of the same index that is being written in that cycle therefore returns the previous contents, and the new word shows up from the following cycle. A synchronous, active-high reset clears every writable entry. The default size is 32 entries of 32 bits with 5-bit indices. Widths and depth are parameters, and their legal range is checked at elaboration.

Top module: `regfile_zr`

## Requirements
- R1: On a rising clock edge with `rst` high, every entry is cleared. From the next cycle on, every index reads 0 on both ports until a write lands.
- R2: With `wr_en` high and `wr_addr` nonzero, `wr_data` is stored into entry `wr_addr` at the rising edge. Both ports return it from the following cycle.
- R3: With `wr_en` low, no entry changes at the clock edge, whatever `wr_addr` and `wr_data` hold.
- R4: Index 0 reads as 0 on both ports at all times. A write to index 0 with `wr_en` high leaves it reading 0.
- R5: Read data is combinational. A change of `rd_addr_a` or `rd_addr_b` between clock edges changes the matching data output in the same cycle.
- R6: When a read index equals `wr_addr` during an enabled write, that port returns the contents from before the edge. The new word appears only after the edge.
- R7: When both read ports carry the same index, `rd_data_a` and `rd_data_b` are equal.
- R8: A write to index k leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all entries |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | ADDR_W (5) | Index of the entry to write |
| wr_data | input | DATA_W (32) | Word to store |
| rd_addr_a | input | ADDR_W (5) | Index for read port A |
| rd_data_a | output | DATA_W (32) | Contents at `rd_addr_a` |
| rd_addr_b | input | ADDR_W (5) | Index for read port B |
| rd_data_b | output | DATA_W (32) | Contents at `rd_addr_b` |

## Verification
The properties assume that every input is a known value at each rising edge and that `rst` is held high through the first edge. The contents before that edge are undefined, and every property is disabled while reset is high. The stimulus drives all inputs on the falling edge only, starts in reset, and uses indices inside the table, so every sampled index and enable is defined. Random traffic draws write and read indices over the full range, index 0 included. This exercises writes to the constant entry, reads that match the write index in the same cycle, and reads where both ports carry one index.

// File: rtl/regfile_zr_pkg.sv
package regfile_zr_pkg;

   // default geometry of the file
   localparam int unsigned RF_ADDR_W_DEF = 5;
   localparam int unsigned RF_DATA_W_DEF = 32;
   localparam int unsigned RF_DEPTH_DEF  = 1 << RF_ADDR_W_DEF;

   // index reserved for the constant-zero entry
   localparam int unsigned RF_ZERO_IDX   = 0;

   // number of read ports on the top level
   localparam int unsigned RF_NUM_RD     = 2;

endpackage

// File: rtl/regfile_zr_wdec.sv
module regfile_zr_wdec #(
   parameter int unsigned ADDR_W = regfile_zr_pkg::RF_ADDR_W_DEF,
   parameter int unsigned DEPTH  = regfile_zr_pkg::RF_DEPTH_DEF
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [DEPTH-1:1]  wr_sel
);

   // one select line per writable entry; entry 0 has none
   for (genvar k = 1; k < DEPTH; k++) begin : g_sel
      assign wr_sel[k] = wr_en && (wr_addr == ADDR_W'(k));
   end

endmodule

// File: rtl/regfile_zr_bank.sv
module regfile_zr_bank #(
   parameter int unsigned DATA_W = regfile_zr_pkg::RF_DATA_W_DEF,
   parameter int unsigned DEPTH  = regfile_zr_pkg::RF_DEPTH_DEF
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [DEPTH-1:1]             wr_sel,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [DEPTH-1:0][DATA_W-1:0] cells
);

   for (genvar k = 0; k < DEPTH; k++) begin : g_cell
      if (k == regfile_zr_pkg::RF_ZERO_IDX) begin : g_const
         // constant entry: no storage
         assign cells[k] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;
            end else if (wr_sel[k]) begin
               q <= wr_data;
            end
         end
         assign cells[k] = q;
      end
   end

endmodule

// File: rtl/regfile_zr_rdmux.sv
module regfile_zr_rdmux #(
   parameter int unsigned ADDR_W = regfile_zr_pkg::RF_ADDR_W_DEF,
   parameter int unsigned DATA_W = regfile_zr_pkg::RF_DATA_W_DEF,
   parameter int unsigned DEPTH  = regfile_zr_pkg::RF_DEPTH_DEF,
   parameter int unsigned NUM_RD = regfile_zr_pkg::RF_NUM_RD
) (
   input  logic [DEPTH-1:0][DATA_W-1:0]  cells,
   input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

   localparam int unsigned FULL_SPAN = 1 << ADDR_W;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      if (DEPTH == FULL_SPAN) begin : g_full
         // every index maps to an entry
         assign rd_data[p] = cells[rd_addr[p]];
      end else begin : g_part
         // indices past the last entry read as zero
         always_comb begin
            rd_data[p] = '0;
            for (int k = 0; k < DEPTH; k++) begin
               if (rd_addr[p] == ADDR_W'(k)) begin
                  rd_data[p] = cells[k];
               end
            end
         end
      end
   end

endmodule

// File: rtl/regfile_zr.sv
module regfile_zr #(
   parameter int unsigned ADDR_W = regfile_zr_pkg::RF_ADDR_W_DEF,
   parameter int unsigned DATA_W = regfile_zr_pkg::RF_DATA_W_DEF,
   parameter int unsigned DEPTH  = regfile_zr_pkg::RF_DEPTH_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b
);

   localparam int unsigned NUM_RD = regfile_zr_pkg::RF_NUM_RD;

   // elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("regfile_zr: ADDR_W must be 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("regfile_zr: DATA_W must be at least 1");
   end
   if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("regfile_zr: DEPTH must be 2..2**ADDR_W");
   end

   logic [DEPTH-1:1]             wr_sel;
   logic [DEPTH-1:0][DATA_W-1:0] cells;
   logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_v;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_data_v;

   regfile_zr_wdec #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) wdec_i (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_sel  (wr_sel)
   );

   regfile_zr_bank #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) bank_i (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .cells   (cells)
   );

   assign rd_addr_v[0] = rd_addr_a;
   assign rd_addr_v[1] = rd_addr_b;

   regfile_zr_rdmux #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .NUM_RD (NUM_RD)
   ) rdmux_i (
      .cells   (cells),
      .rd_addr (rd_addr_v),
      .rd_data (rd_data_v)
   );

   assign rd_data_a = rd_data_v[0];
   assign rd_data_b = rd_data_v[1];

endmodule

// File: rtl/regfile_zr_chk.sv
module regfile_zr_chk #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [DATA_W-1:0] rd_data_b
);

   AST_RESET_CLEARS_A: assert property (@(posedge clk) rst |=> (rd_data_a == '0)); // R1
   AST_RESET_CLEARS_B: assert property (@(posedge clk) rst |=> (rd_data_b == '0)); // R1

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr != '0) |=>
         (rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data))); // R2

   AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || wr_addr != rd_addr_a) |=>
         (rd_addr_a != $past(rd_addr_a)) || (rd_data_a == $past(rd_data_a))); // R3

   AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || wr_addr != rd_addr_b) |=>
         (rd_addr_b != $past(rd_addr_b)) || (rd_data_b == $past(rd_data_b))); // R8

   AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == '0) |-> (rd_data_a == '0)); // R4
   AST_ZERO_B: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_b == '0) |-> (rd_data_b == '0)); // R4

   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b)); // R7

endmodule

bind regfile_zr regfile_zr_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (.*);

// File: tb/regfile_zr_tb_top.sv
`timescale 1ns/1ps
module regfile_zr_tb_top;

   localparam int AW = 5;
   localparam int DW = 32;
   localparam int NE = 1 << AW;

   typedef struct {
      logic [DW-1:0] exp;
      bit            port_b;
      string         req;
   } item_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr_a = '0;
   logic [DW-1:0] rd_data_a;
   logic [AW-1:0] rd_addr_b = '0;
   logic [DW-1:0] rd_data_b;

   logic [DW-1:0] shadow [NE];
   item_t         q [$];
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   regfile_zr dut_i (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr_a (rd_addr_a),
      .rd_data_a (rd_data_a),
      .rd_addr_b (rd_addr_b),
      .rd_data_b (rd_data_b)
   );

   function automatic void compare(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                                   input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endfunction

   // driver: one cycle of stimulus, expected reads pushed before the edge
   task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string req);
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_addr_a = ra; rd_addr_b = rb;
      q.push_back('{exp: shadow[ra], port_b: 1'b0, req: req});
      q.push_back('{exp: shadow[rb], port_b: 1'b1, req: req});
      if (we && wa != '0) shadow[wa] = wd;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      foreach (shadow[i]) shadow[i] = '0;
   endtask

   // monitor: pops expected items while the outputs are settled
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            compare(it.port_b ? rd_data_b : rd_data_a, it.exp, it.req,
                    it.port_b ? "port b" : "port a");
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      foreach (shadow[i]) shadow[i] = '0;
      do_reset();

      // R1: every index reads zero after reset
      for (int i = 0; i < NE; i++) cyc(1'b0, '0, '0, AW'(i), AW'(NE-1-i), "R1");

      // R2: fill every writable entry, read back one cycle later
      for (int i = 1; i < NE; i++)
         cyc(1'b1, AW'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), AW'(i-1), AW'(i), "R2");
      for (int i = 0; i < NE; i++) cyc(1'b0, '0, '0, AW'(i), AW'(i), "R2");

      // R4: write to index 0 is dropped
      cyc(1'b1, '0, 32'hFFFFFFFF, '0, '0, "R4");
      cyc(1'b0, '0, '0, '0, '0, "R4");

      // R3: disabled write changes nothing
      cyc(1'b0, AW'(5), 32'hDEADBEEF, AW'(5), AW'(6), "R3");
      cyc(1'b0, '0, '0, AW'(5), AW'(6), "R3");

      // R6: same-cycle read returns old contents, new word next cycle
      cyc(1'b1, AW'(12), 32'h12345678, AW'(12), AW'(12), "R6");
      cyc(1'b0, '0, '0, AW'(12), AW'(11), "R6");

      // R8: neighbours of a written entry keep their contents
      cyc(1'b1, AW'(9), 32'h0BADF00D, AW'(8), AW'(10), "R8");
      cyc(1'b0, '0, '0, AW'(8), AW'(10), "R8");

      // R7: both ports on one index
      cyc(1'b0, '0, '0, AW'(31), AW'(31), "R7");

      // R5: address changes between edges show up without a clock edge
      @(negedge clk);
      rd_addr_a = AW'(3); rd_addr_b = AW'(7);
      #0.5;
      compare(rd_data_a, shadow[3], "R5", "port a first index");
      rd_addr_a = AW'(7); rd_addr_b = AW'(3);
      #0.5;
      compare(rd_data_a, shadow[7], "R5", "port a second index");
      compare(rd_data_b, shadow[3], "R5", "port b second index");

      // random traffic across the full index range, index 0 included
      for (int n = 0; n < 3000; n++)
         cyc(1'($urandom), AW'($urandom), $urandom, AW'($urandom), AW'($urandom), "R2,R8");

      // R1: reset after traffic clears everything
      do_reset();
      for (int i = 0; i < NE; i++) cyc(1'b0, '0, '0, AW'(i), AW'(i), "R1");

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule